// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers a set of event lines (seven by default) into a single interrupt pin for a processor. Each line is captured into a status register that the processor can read at any time. A mask register decides which captured lines may drive the interrupt pin. A line that is masked still shows in the status register.

Two clearing behaviours can be selected at run time, and both use the same status register. In clear-on-read mode a status bit stays set after its event goes away, and it is cleared only by a status-read strobe. In follow-level mode the status register copies the event lines one cycle late, and a read has no effect on it. The pin is always actively driven to one of its two levels, and a configuration bit selects which level means "active".

Top module: `irq_hub`

## Requirements
- R1: After reset the status register and the mask are all zero, the block is in clear-on-read mode with active-high polarity, and `irq_pin` is 0.
- R2: An event line high at a clock edge sets its status bit, seen on `stat_q` after that edge, whether or not the line is masked.
- R3: In clear-on-read mode (`cfg_level_mode`=0) a set status bit stays set after its event line goes low, as long as no read strobe occurs.
- R4: In clear-on-read mode a cycle with `stat_rd`=1 clears every status bit that was set in that cycle. Any event line high in the same cycle leaves its bit set afterwards.
- R5: In follow-level mode (`cfg_level_mode`=1) `stat_q` equals the event lines of the previous cycle, and `stat_rd` has no effect.
- R6: The interrupt is active exactly when at least one status bit has its mask bit set to 1. Masked status bits never make it active.
- R7: With `cfg_active_low`=0 the active level of `irq_pin` is 1. With `cfg_active_low`=1 it is 0. The pin sits at the opposite value when the interrupt is inactive.
- R8: A mask write (`mask_we`) or a configuration write (`cfg_we`) takes effect at the next clock edge. Until then the previous settings govern the status update.
- R9: Event bit k, status bit k and mask bit k refer to the same source, for every k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | N_SRC | Event lines, one per source |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | N_SRC | New mask value, 1 = source enabled |
| cfg_we | input | 1 | Write strobe for the mode and polarity bits |
| cfg_level_mode | input | 1 | 0 = clear-on-read, 1 = follow-level |
| cfg_active_low | input | 1 | 1 = interrupt pin is active low |
| stat_rd | input | 1 | Status-read strobe, one cycle per read |
| stat_q | output | N_SRC | Status register |
| irq_pin | output | 1 | Interrupt output, always actively driven |

## Verification
The hardest case is a read strobe that lands in the same cycle as a fresh event on a line whose earlier event is already latched. Only that timing shows whether the clear and the new capture are ordered correctly. The stimulus latches two lines, then issues the strobe together with one already-latched line and one new line, and expects only those two lines to stay set. A second difficult case is a mode or polarity change written in the same cycle as an event or a read. The bench writes these together on purpose, so that the old mode must govern that cycle's update.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;

  typedef enum logic {
    CLR_ON_READ  = 1'b0,
    FOLLOW_LEVEL = 1'b1
  } clr_mode_e;

  typedef enum logic {
    POL_HIGH = 1'b0,
    POL_LOW  = 1'b1
  } pin_pol_e;

endpackage

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
  import irq_hub_pkg::*;
#(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic             cfg_we,
  input  logic             cfg_mode,
  input  logic             cfg_low,
  output logic [N_SRC-1:0] mask_q,
  output clr_mode_e        mode_q,
  output pin_pol_e         pol_q
);

  localparam logic [N_SRC-1:0] MASK_RST = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
    end else if (mask_we) begin
      mask_q <= mask_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CLR_ON_READ;
      pol_q  <= POL_HIGH;
    end else if (cfg_we) begin
      mode_q <= clr_mode_e'(cfg_mode);
      pol_q  <= pin_pol_e'(cfg_low);
    end
  end

endmodule

// File: rtl/irq_status_bank.sv
`timescale 1ns/1ps
module irq_status_bank
  import irq_hub_pkg::*;
#(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  clr_mode_e        mode,
  input  logic             rd,
  output logic [N_SRC-1:0] stat_q,
  output logic [N_SRC-1:0] rd_clear
);

  // Next value of one status bit under the selected clearing rule.
  function automatic logic bit_next(clr_mode_e m, logic cur, logic ev, logic clr);
    logic kept;
    if (m == FOLLOW_LEVEL) begin
      return ev;
    end
    kept = cur & ~clr;
    return kept | ev;
  endfunction

  for (genvar k = 0; k < N_SRC; k++) begin : g_bit
    logic nxt;
    assign rd_clear[k] = rd & stat_q[k] & (mode == CLR_ON_READ);
    assign nxt         = bit_next(mode, stat_q[k], evt[k], rd_clear[k]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[k] <= 1'b0;
      else        stat_q[k] <= nxt;
    end
  end

endmodule

// File: rtl/irq_out_drive.sv
`timescale 1ns/1ps
module irq_out_drive
  import irq_hub_pkg::*;
#(
  parameter int N_SRC = 7
) (
  input  logic [N_SRC-1:0] stat,
  input  logic [N_SRC-1:0] mask,
  input  pin_pol_e         pol,
  output logic             active,
  output logic             pin
);

  function automatic logic any_enabled(logic [N_SRC-1:0] s, logic [N_SRC-1:0] m);
    return |(s & m);
  endfunction

  function automatic logic to_level(logic act, pin_pol_e p);
    return (p == POL_LOW) ? ~act : act;
  endfunction

  assign active = any_enabled(stat, mask);
  assign pin    = to_level(active, pol);

endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_SRC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             mask_we,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic             cfg_we,
  input  logic             cfg_level_mode,
  input  logic             cfg_active_low,
  input  logic             stat_rd,
  output logic [N_SRC-1:0] stat_q,
  output logic             irq_pin
);

  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] rd_clear;
  clr_mode_e        mode_q;
  pin_pol_e         pol_q;
  logic             irq_active;
  logic             level_mode;
  logic             low_pol;

  assign level_mode = (mode_q == FOLLOW_LEVEL);
  assign low_pol    = (pol_q == POL_LOW);

  irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .cfg_we     (cfg_we),
    .cfg_mode   (cfg_level_mode),
    .cfg_low    (cfg_active_low),
    .mask_q     (mask_q),
    .mode_q     (mode_q),
    .pol_q      (pol_q)
  );

  irq_status_bank #(.N_SRC(N_SRC)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_i),
    .mode     (mode_q),
    .rd       (stat_rd),
    .stat_q   (stat_q),
    .rd_clear (rd_clear)
  );

  irq_out_drive #(.N_SRC(N_SRC)) u_drv (
    .stat   (stat_q),
    .mask   (mask_q),
    .pol    (pol_q),
    .active (irq_active),
    .pin    (irq_pin)
  );

endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk #(
  parameter int N_SRC = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt_i,
  input logic             mask_we,
  input logic [N_SRC-1:0] mask_wdata,
  input logic             stat_rd,
  input logic [N_SRC-1:0] stat_q,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] rd_clear,
  input logic             level_mode,
  input logic             low_pol,
  input logic             irq_pin
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (stat_q == '0 && irq_pin == 1'b0)); // R1

  AST_EVT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    1'b1 |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!level_mode && !stat_rd) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R3

  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!level_mode && stat_rd) |=> (stat_q == $past(evt_i))); // R4

  AST_CLEAR_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_clear & ~stat_q) == '0)); // R4

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    level_mode |=> (stat_q == $past(evt_i))); // R5

  AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin == ((|(stat_q & mask_q)) ^ low_pol)); // R6

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    mask_we |=> (mask_q == $past(mask_wdata))); // R8

endmodule

bind irq_hub irq_hub_chk #(.N_SRC(N_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .mask_we    (mask_we),
  .mask_wdata (mask_wdata),
  .stat_rd    (stat_rd),
  .stat_q     (stat_q),
  .mask_q     (mask_q),
  .rd_clear   (rd_clear),
  .level_mode (level_mode),
  .low_pol    (low_pol),
  .irq_pin    (irq_pin)
);

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;

  localparam int N = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic         cfg_we = 1'b0;
  logic         cfg_level_mode = 1'b0;
  logic         cfg_active_low = 1'b0;
  logic         stat_rd = 1'b0;
  logic [N-1:0] stat_q;
  logic         irq_pin;

  always #2.5 clk = ~clk;

  irq_hub #(.N_SRC(N)) u_irq_hub (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .cfg_we(cfg_we), .cfg_level_mode(cfg_level_mode),
    .cfg_active_low(cfg_active_low), .stat_rd(stat_rd),
    .stat_q(stat_q), .irq_pin(irq_pin)
  );

  typedef struct {
    logic [N-1:0] st;
    logic         pin;
    string        tag;
  } exp_t;

  exp_t  sb_q[$];
  int    checks = 0;
  int    errors = 0;
  logic  done = 1'b0;

  // Bench-side model of the registers, written from the requirements.
  logic [N-1:0] m_stat = '0;
  logic [N-1:0] m_mask = '0;
  logic         m_level = 1'b0;
  logic         m_low = 1'b0;

  function automatic logic exp_pin(logic [N-1:0] s, logic [N-1:0] m, logic low);
    logic any;
    any = 1'b0;
    for (int i = 0; i < N; i++) if (s[i] && m[i]) any = 1'b1;
    return low ? !any : any;
  endfunction

  task automatic step(input logic [N-1:0] ev, input logic rd,
                      input logic mw, input logic [N-1:0] mv,
                      input logic cw, input logic lv, input logic al,
                      input string tag);
    exp_t e;
    logic [N-1:0] ns;
    @(negedge clk);
    evt_i = ev; stat_rd = rd; mask_we = mw; mask_wdata = mv;
    cfg_we = cw; cfg_level_mode = lv; cfg_active_low = al;
    if (m_level) ns = ev;
    else         ns = (rd ? '0 : m_stat) | ev;
    m_stat = ns;
    if (mw) m_mask = mv;
    if (cw) begin m_level = lv; m_low = al; end
    @(posedge clk);
    #1;
    e.st = m_stat; e.pin = exp_pin(m_stat, m_mask, m_low); e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic quiet(input string tag);
    step('0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (stat_q !== e.st || irq_pin !== e.pin) begin
        errors++;
        $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                 e.tag, stat_q, irq_pin, e.st, e.pin);
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (stat_q !== '0 || irq_pin !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: stat=%h irq=%b expected stat=00 irq=0", stat_q, irq_pin);
    end
    @(negedge clk); rst_n = 1'b1;
    quiet("R1 idle after reset");

    // Masked capture, then hold
    step(7'h04, 0, 0, '0, 0, 0, 0, "R2 masked capture R6");
    quiet("R3 hold 1");
    quiet("R3 hold 2");
    step('0, 0, 1, 7'h04, 0, 0, 0, "R8 mask enables R6");
    step('0, 1, 0, '0, 0, 0, 0, "R4 read clears");

    // Walking single bits through every source
    for (int k = 0; k < N; k++) begin
      step(7'(1 << k), 0, 1, 7'(1 << k), 0, 0, 0, "R9 walk capture");
      step('0, 0, 1, 7'(~(1 << k)), 0, 0, 0, "R9 walk other mask R6");
      step('0, 1, 0, '0, 0, 0, 0, "R9 walk read");
    end

    // Read colliding with new and repeated events
    step(7'h11, 0, 1, 7'h7F, 0, 0, 0, "R2 two lines");
    step(7'h50, 1, 0, '0, 0, 0, 0, "R4 read with same-cycle events");
    quiet("R3 pending survives");
    step('0, 1, 0, '0, 0, 0, 0, "R4 read empties");

    // Polarity
    step('0, 0, 0, '0, 1, 0, 1, "R7 low polarity idle");
    step(7'h02, 0, 0, '0, 0, 0, 0, "R7 low polarity active");
    step('0, 1, 0, '0, 0, 0, 0, "R7 low after read");

    // Mode change written with an event: old mode governs that edge
    step(7'h08, 0, 0, '0, 1, 1, 0, "R8 cfg write same cycle");
    step('0, 0, 0, '0, 0, 0, 0, "R5 level drops");
    step(7'h21, 1, 0, '0, 0, 0, 0, "R5 read ignored");
    step(7'h21, 1, 0, '0, 0, 0, 0, "R5 read ignored again");
    step(7'h01, 0, 1, 7'h20, 0, 0, 0, "R5 follow with mask R6");
    quiet("R5 all low");

    // Back to clear-on-read
    step(7'h40, 0, 0, '0, 1, 0, 0, "R8 back to latched");
    quiet("R3 latched again");
    step('0, 0, 1, 7'h40, 0, 0, 0, "R6 enable bit 6");
    step('0, 1, 0, '0, 0, 0, 0, "R4 final read");
    quiet("R1 drained");

    repeat (2) @(posedge clk);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
    end
  end

endmodule